// File: doc/BRIEF.md
# Fuse Array Burst Read Controller

This block sits on a simple 32-bit register port and fetches bytes from a one-time-programmable fuse array of 1024 bytes (8192 fuses). Software loads a start byte address and a burst length into the control register, sets the read-enable bit, and the block steps through the bytes. It presents each address to the array, waits a programmable setup time, raises the read strobe for a programmable width, and captures the byte at the end of the strobe. Captured bytes are packed into eight 32-bit data registers. When the last byte is in, a status flag rises and, if enabled, an interrupt output follows it. The fuse array is modelled inside the block as a registered byte-wide store. The array is divided into seven fixed-size regions that hold 64, 128, 128, 3520, 8, 2296 and 2048 bits, from the lowest address to the highest. The reader treats all regions alike.

The sequencer is a three-state machine. Its states are SEQ_IDLE (no burst), SEQ_SETUP (address presented, strobe low) and SEQ_STROBE (strobe high). It has four transitions. START goes from SEQ_IDLE to SEQ_SETUP on an accepted control write with read enable. ARM goes from SEQ_SETUP to SEQ_STROBE when the setup count expires. NEXT goes from SEQ_STROBE back to SEQ_SETUP when a byte is captured and more bytes remain. FINISH goes from SEQ_STROBE to SEQ_IDLE when the last byte is captured. The programming-related control bits and the write timing fields are held only as register storage.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0. A read of an unmapped or non-word-aligned address returns 0.
- R2: The control register is at offset 0x0. It stores start address in bits [30:21], length-minus-one in [20:16], program enable at 15, write enable at 1 and read enable at 0. All other bits read 0. A control write with bit 0 clear only stores the value and starts nothing.
- R3: The configuration register is at offset 0x4. It stores interrupt enable at bit 31, read setup adjust in [23:20], read strobe in [19:16] and write timing in [15:0]. Bits [30:24] read 0.
- R4: For each byte, the setup phase lasts adjust+1 cycles and the strobe phase lasts strobe+4 cycles. A burst of N bytes, started by a control write at clock edge E0, sets read-done at edge E0 + N·(adjust+5+strobe), and not earlier. The adjust and strobe values are sampled when the burst starts.
- R5: The fuse byte at address a equals ((3·a) mod 256) XOR (64·(a div 256)) XOR 0x15. Burst byte k (address start+k) lands in data word k div 4 (offset 0xC + 4·word), in bits [8·(k mod 4)+7 : 8·(k mod 4)].
- R6: The status register is at 0x8, with read-done at bit 0 and write-done at bit 1, which is always 0. Starting a burst clears read-done. Completion sets read-done and clears control bit 0. Bit 0 reads 1 while the burst runs.
- R7: A control write during a burst is ignored, so neither the control readback nor the burst changes.
- R8: Data register bytes that a burst does not reach keep their previous value.
- R9: `irq` is 1 exactly while read-done is 1 and interrupt enable is set.
- R10: A burst address that passes byte 1023 continues at byte 0.
- R11: Writes to the status and data registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wen | input | 1 | Write strobe for the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq | output | 1 | Completion interrupt |

## Verification
Register reads are combinational and are sampled in the same low clock phase. A configuration or control write shows up in the readback after its own edge. The bench writes on a falling edge and reads at the next falling edge. Read-done and `irq` are due N·(adjust+5+strobe) edges after the start edge. The bench counts falling edges from the start write and reads status one cycle before that edge, where it must still be 0, and again just after it, where it must be 1. The data words and the control readback are compared at that same point against a model of the fuse contents and the packing rule.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETUP  = 2'd1,
        SEQ_STROBE = 2'd2
    } seq_state_e;

    // bit positions decoded by software
    localparam int CTRL_ADDR_LSB  = 21;
    localparam int CTRL_LEN_LSB   = 16;
    localparam int CTRL_PROG_BIT  = 15;
    localparam int CTRL_WRITE_BIT = 1;
    localparam int CTRL_READ_BIT  = 0;
    localparam int CFG_IRQ_BIT    = 31;
    localparam int CFG_RADJ_LSB   = 20;
    localparam int CFG_RSTB_LSB   = 16;
    localparam int TIME_W         = 4;
    localparam logic [31:0] CFG_MASK = 32'h80FF_FFFF;

    // strobe phase is strobe field plus this many cycles
    localparam int STROBE_EXTRA = 4;

    // register slots, word index on the bus
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_CFG  = 1;
    localparam int SLOT_STAT = 2;
    localparam int SLOT_DATA = 3;

    // fuse contents of the array model
    function automatic logic [7:0] fuse_pattern(input int unsigned a);
        int unsigned v;
        v = (a * 3) ^ ((a >> 8) << 6) ^ 32'h15;
        return v[7:0];
    endfunction

endpackage

// File: rtl/fuse_array.sv
module fuse_array
    import fuse_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_strobe,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_strobe) begin
            rd_data <= fuse_pattern(int'(rd_addr));
        end
    end

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int AW = 10,
    parameter int LW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AW-1:0]     start_addr_i,
    input  logic [LW-1:0]     len_m1_i,
    input  logic [TIME_W-1:0] adj_i,
    input  logic [TIME_W-1:0] strb_i,
    output logic [AW-1:0]     fuse_addr_o,
    output logic              fuse_strobe_o,
    input  logic [7:0]        fuse_data_i,
    output logic              cap_valid_o,
    output logic [LW-1:0]     cap_index_o,
    output logic [7:0]        cap_byte_o,
    output logic              last_o,
    output logic              busy_o
);

    localparam int CNT_W = $clog2((1 << TIME_W) + STROBE_EXTRA);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LW-1:0]     idx_q;
    logic [LW-1:0]     len_q;
    logic [AW-1:0]     addr_q;
    logic [TIME_W-1:0] adj_q;
    logic [TIME_W-1:0] strb_q;
    logic              setup_end;
    logic              hold_end;

    assign setup_end = (state_q == SEQ_SETUP) && (cnt_q == CNT_W'(adj_q));
    assign hold_end  = (state_q == SEQ_STROBE) &&
                       (cnt_q == CNT_W'(strb_q) + CNT_W'(STROBE_EXTRA - 1));

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            len_q   <= '0;
            addr_q  <= '0;
            adj_q   <= '0;
            strb_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin            // START
                        state_q <= SEQ_SETUP;
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        addr_q  <= start_addr_i;
                        len_q   <= len_m1_i;
                        adj_q   <= adj_i;
                        strb_q  <= strb_i;
                    end
                end
                SEQ_SETUP: begin
                    if (setup_end) begin          // ARM
                        state_q <= SEQ_STROBE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_STROBE: begin
                    if (hold_end) begin           // NEXT or FINISH
                        cnt_q   <= '0;
                        addr_q  <= addr_q + 1'b1;
                        idx_q   <= idx_q + 1'b1;
                        state_q <= (idx_q == len_q) ? SEQ_IDLE : SEQ_SETUP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        fuse_strobe_o = 1'b0;
        busy_o        = 1'b1;
        unique case (state_q)
            SEQ_IDLE:   busy_o        = 1'b0;
            SEQ_SETUP:  fuse_strobe_o = 1'b0;
            SEQ_STROBE: fuse_strobe_o = 1'b1;
            default:    busy_o        = 1'b0;
        endcase
        fuse_addr_o = addr_q;
        cap_valid_o = hold_end;
        cap_index_o = idx_q;
        cap_byte_o  = fuse_data_i;
        last_o      = (idx_q == len_q);
    end

    // R4: the captured byte was strobed on the previous edge too
    assert_cap_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_o |-> (fuse_strobe_o && $past(fuse_strobe_o)));

    // R4: address does not move while the strobe is held
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_strobe_o && $past(fuse_strobe_o)) |-> $stable(fuse_addr_o));

    // R10: top address steps to zero
    assert_addr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid_o && !last_o && (fuse_addr_o == '1)) |=> (fuse_addr_o == '0));

endmodule

// File: rtl/fuse_databank.sv
module fuse_databank #(
    parameter int WORDS = 8,
    parameter int IW    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_valid_i,
    input  logic [IW-1:0]       cap_index_i,
    input  logic [7:0]          cap_byte_i,
    output logic [WORDS*32-1:0] words_o
);

    generate
        for (genvar g = 0; g < WORDS; g++) begin : g_word
            logic [31:0] w_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    w_q <= '0;
                end else if (cap_valid_i && (cap_index_i[IW-1:2] == (IW-2)'(g))) begin
                    w_q[8*cap_index_i[1:0] +: 8] <= cap_byte_i;
                end
            end
            assign words_o[32*g +: 32] = w_q;
        end
    endgenerate

    // R8: no capture, no change anywhere in the bank
    assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid_i |=> $stable(words_o));

endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
    import fuse_pkg::*;
#(
    parameter int FUSE_BYTES = 1024,
    parameter int BURST_MAX  = 32,
    parameter int BUS_AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    localparam int FA_W       = $clog2(FUSE_BYTES);
    localparam int LEN_W      = $clog2(BURST_MAX);
    localparam int DATA_WORDS = BURST_MAX / 4;
    localparam int SLOT_W     = BUS_AW - 2;
    localparam logic [31:0] CTRL_MASK =
        ((32'(1) << FA_W) - 1) << CTRL_ADDR_LSB |
        ((32'(1) << LEN_W) - 1) << CTRL_LEN_LSB |
        (32'(1) << CTRL_PROG_BIT) | (32'(1) << CTRL_WRITE_BIT) |
        (32'(1) << CTRL_READ_BIT);

    logic [SLOT_W-1:0]       slot;
    logic                    aligned;
    logic                    ctrl_hit, cfg_hit, start;
    logic [31:0]             ctrl_q, cfg_q;
    logic                    rd_done_q;
    logic                    busy, cap_valid, last, last_cap, fuse_strobe;
    logic [FA_W-1:0]         fuse_addr;
    logic [7:0]              fuse_data, cap_byte;
    logic [LEN_W-1:0]        cap_index;
    logic [DATA_WORDS*32-1:0] data_flat;

    assign slot     = reg_addr[BUS_AW-1:2];
    assign aligned  = (reg_addr[1:0] == 2'b00);
    assign ctrl_hit = reg_wen && aligned && (int'(slot) == SLOT_CTRL);
    assign cfg_hit  = reg_wen && aligned && (int'(slot) == SLOT_CFG);
    assign start    = ctrl_hit && !busy && reg_wdata[CTRL_READ_BIT];
    assign last_cap = cap_valid && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            cfg_q     <= '0;
            rd_done_q <= 1'b0;
        end else begin
            if (ctrl_hit && !busy) begin
                ctrl_q <= reg_wdata & CTRL_MASK;
            end else if (last_cap) begin
                ctrl_q[CTRL_READ_BIT] <= 1'b0;
            end
            if (cfg_hit) begin
                cfg_q <= reg_wdata & CFG_MASK;
            end
            if (start) begin
                rd_done_q <= 1'b0;
            end else if (last_cap) begin
                rd_done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            if (int'(slot) == SLOT_CTRL) reg_rdata = ctrl_q;
            if (int'(slot) == SLOT_CFG)  reg_rdata = cfg_q;
            if (int'(slot) == SLOT_STAT) reg_rdata = {30'b0, 1'b0, rd_done_q};
            for (int i = 0; i < DATA_WORDS; i++) begin
                if (int'(slot) == SLOT_DATA + i) reg_rdata = data_flat[32*i +: 32];
            end
        end
    end

    assign irq = cfg_q[CFG_IRQ_BIT] && rd_done_q;

    fuse_seq #(
        .AW (FA_W),
        .LW (LEN_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .start_addr_i  (reg_wdata[CTRL_ADDR_LSB +: FA_W]),
        .len_m1_i      (reg_wdata[CTRL_LEN_LSB +: LEN_W]),
        .adj_i         (cfg_q[CFG_RADJ_LSB +: TIME_W]),
        .strb_i        (cfg_q[CFG_RSTB_LSB +: TIME_W]),
        .fuse_addr_o   (fuse_addr),
        .fuse_strobe_o (fuse_strobe),
        .fuse_data_i   (fuse_data),
        .cap_valid_o   (cap_valid),
        .cap_index_o   (cap_index),
        .cap_byte_o    (cap_byte),
        .last_o        (last),
        .busy_o        (busy)
    );

    fuse_array #(
        .DEPTH (FUSE_BYTES),
        .AW    (FA_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (fuse_strobe),
        .rd_addr   (fuse_addr),
        .rd_data   (fuse_data)
    );

    fuse_databank #(
        .WORDS (DATA_WORDS),
        .IW    (LEN_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_valid_i (cap_valid),
        .cap_index_i (cap_index),
        .cap_byte_i  (cap_byte),
        .words_o     (data_flat)
    );

    // R6: done never coexists with a running burst
    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && rd_done_q));

    // R6: burst end leaves done set and read enable clear
    assert_end_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rd_done_q && !ctrl_q[CTRL_READ_BIT]));

    // R7: control contents frozen across a write during a burst
    assert_ctrl_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_hit) |=> $stable(ctrl_q[31:1]));

    // R9: interrupt only outside a burst
    assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

endmodule

// File: tb/test_fuse_rd_ctrl.sv
module test_fuse_rd_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    bit irq_en   = 0;
    logic [31:0] mdl [8];

    always #10 clk = ~clk;   // 50 MHz

    fuse_rd_ctrl i_fuse_rd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    function automatic logic [7:0] exp_byte(input int a);
        int v;
        v = ((a * 3) % 256) ^ (64 * (a / 256)) ^ 'h15;
        return v[7:0];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = 6'(a);
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 6'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic check_words(input string req);
        logic [31:0] v;
        for (int w = 0; w < 8; w++) begin
            rd(12 + 4 * w, v);
            chk(req, $sformatf("data word %0d", w), v, mdl[w]);
        end
    endtask

    task automatic run_burst(input int st, input int ln, input int adj,
                             input int stb, input bit poke, input string req);
        int n, t, waitn;
        logic [31:0] base, v;
        n    = ln + 1;
        t    = adj + 5 + stb;
        base = (32'(st) << 21) | (32'(ln) << 16);
        wr(4, (32'(irq_en) << 31) | (32'(adj) << 20) | (32'(stb) << 16));
        wr(0, base | 32'h1);
        rd(8, v);
        chk("R6", "done cleared at start", v, 32'h0);
        rd(0, v);
        chk("R6", "read enable held while busy", v, base | 32'h1);
        if (poke) begin
            wr(0, ((~base) & 32'h7FFF_8002) | 32'h1);
            waitn = n * t - 3;
        end else begin
            waitn = n * t - 1;
        end
        repeat (waitn) @(negedge clk);
        rd(8, v);
        chk("R4", "done one cycle early", v, 32'h0);
        @(negedge clk);
        rd(8, v);
        chk("R4", "done on time", v, 32'h1);
        chk("R9", "irq with done", 32'(irq), 32'(irq_en));
        rd(0, v);
        chk(poke ? "R7" : "R6", "control after burst", v, base);
        for (int k = 0; k < n; k++) begin
            int a;
            a = (st + k) % 1024;
            mdl[k / 4][8 * (k % 4) +: 8] = exp_byte(a);
        end
        check_words(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R4 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int w = 0; w < 8; w++) mdl[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int r = 0; r < 11; r++) begin
            rd(4 * r, v);
            chk("R1", $sformatf("reset reg %0d", r), v, 32'h0);
        end
        rd(6'h30, v);
        chk("R1", "unmapped read", v, 32'h0);
        chk("R1", "irq after reset", 32'(irq), 32'h0);

        // R2 control storage, no start without bit 0
        wr(0, 32'hFFFF_FFFE);
        rd(0, v);
        chk("R2", "control mask", v, 32'h7FFF_8002);
        repeat (40) @(negedge clk);
        rd(8, v);
        chk("R2", "no burst without read enable", v, 32'h0);
        check_words("R2");
        rd(1, v);
        chk("R1", "unaligned read", v, 32'h0);
        wr(0, 32'h0);

        // R3 configuration storage
        wr(4, 32'hFFFF_FFFF);
        rd(4, v);
        chk("R3", "config mask", v, 32'h80FF_FFFF);
        wr(4, 32'h0);

        // directed bursts
        run_burst(0, 31, 0, 0, 0, "R5");        // fastest full aligned burst
        run_burst(40, 0, 15, 15, 0, "R8");      // one byte, slowest timing
        run_burst(1020, 7, 1, 2, 0, "R10");     // wraps past the top
        run_burst(500, 2, 2, 0, 0, "R8");       // partial overwrite

        // R9 interrupt follows done and drops on a new start
        irq_en = 1;
        run_burst(5, 5, 2, 3, 0, "R9");
        wr(0, (32'd200 << 21) | (32'd3 << 16) | 32'h1);
        chk("R9", "irq drops when burst starts", 32'(irq), 32'h0);
        repeat (4 * 10) @(negedge clk);
        irq_en = 0;
        for (int k = 0; k < 4; k++) mdl[0][8 * k +: 8] = exp_byte(200 + k);
        check_words("R5");
        wr(4, 32'h0);
        chk("R9", "irq off when disabled", 32'(irq), 32'h0);

        // R7 control write during a burst
        run_burst(100, 12, 3, 1, 1, "R7");

        // R11 writes to status and data ignored
        wr(8, 32'hFFFF_FFFF);
        rd(8, v);
        chk("R11", "status write ignored", v, 32'h1);
        wr(12, 32'hDEAD_BEEF);
        wr(40, 32'h1234_5678);
        check_words("R11");

        // random bursts
        for (int i = 0; i < 10; i++) begin
            irq_en = 1'($urandom % 2);
            run_burst(int'($urandom % 1024), int'($urandom % 32),
                      int'($urandom % 16), int'($urandom % 16), 0, "R5");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule